// File: doc/BRIEF.md
# DMA Minor-Loop Transfer Sequencer

This block carries one DMA channel descriptor through a single minor loop. On a start pulse it latches the source and destination pointers, the signed per-access offsets, the two access sizes, the minor-loop byte count, the current and starting iteration counts and the end-of-major-loop pointer adjustments. It then drives a two-stage pipelined bus master. Every beat is a dual-address transfer: data is read from the source and then written to the destination, through an internal byte-lane buffer. The buffer packs several narrow reads into one wide write, or splits one wide read into several narrow writes.

Once the last write has been issued, the block spends one cycle presenting the updated descriptor fields for storage. It also pulses either a minor-loop or a major-loop completion. When the iteration count runs out, the final pointer adjustments are folded into the written-back addresses and the count is reloaded from its starting value. A descriptor that cannot be executed is rejected at start with an error pulse and no bus traffic.

Top module: `dma_minor_seq`

## Requirements
- R1: A start pulse is taken only while `busy_o` is low. `busy_o` is high from the cycle after an accepted start through the write-back cycle, and low in the cycle after it. A start pulse while busy has no effect on the transfer or on the written-back fields.
- R2: A start is rejected when any of these holds: a size code is 3, the byte count is zero, the iteration count is zero, or the byte count is not a multiple of the larger access size. On rejection `err_o` pulses for one cycle in the cycle after start, `busy_o` stays low and no bus request is made.
- R3: With equal source and destination sizes, the bus sequence alternates one read and one write until the byte count has been moved.
- R4: With unequal sizes, each group of larger-size bytes is moved as all of its reads followed by all of its writes. For example, 16-bit reads into a 32-bit destination give read, read, write.
- R5: Size codes on `bus_size_o` and the size inputs are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. An access of address A places its bytes on the lanes starting at lane A[1:0], and reads take their bytes from the same lanes.
- R6: An access is accepted in a cycle where `bus_req_o` and `bus_ready_i` are both high. While `bus_ready_i` is low, the request, address, direction and size hold steady. Read data is sampled in the cycle after acceptance, and write data is driven in the cycle after acceptance. The next address may be accepted in that same cycle.
- R7: After every accepted read the source pointer advances by the signed 16-bit source offset. After every accepted write the destination pointer advances by the signed destination offset.
- R8: In the write-back cycle `wb_valid_o` pulses once and shows the advanced pointers and the iteration count minus one. When that count is non-zero, `minor_done_o` pulses in the same cycle.
- R9: When the iteration count minus one is zero, the written-back pointers also include the source and destination adjustments, the written-back count equals the starting count, and `major_done_o` pulses instead of `minor_done_o`.
- R10: The bytes written to the destination, in write order, equal the bytes read from the source, in read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when idle |
| src_addr_i | input | 32 | Source pointer |
| dst_addr_i | input | 32 | Destination pointer |
| src_step_i | input | 16 | Signed source offset per read |
| dst_step_i | input | 16 | Signed destination offset per write |
| src_size_i | input | 2 | Source access size code |
| dst_size_i | input | 2 | Destination access size code |
| minor_bytes_i | input | 16 | Bytes moved per minor loop |
| iter_cur_i | input | 16 | Current iteration count |
| iter_start_i | input | 16 | Starting iteration count for reload |
| src_adj_i | input | 32 | Source pointer adjustment at major end |
| dst_adj_i | input | 32 | Destination pointer adjustment at major end |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Descriptor rejected pulse |
| bus_req_o | output | 1 | Address-phase request |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | 32 | Access address |
| bus_size_o | output | 2 | Access size code |
| bus_ready_i | input | 1 | Address phase accepted |
| bus_wdata_o | output | 32 | Write data, data phase |
| bus_rdata_i | input | 32 | Read data, data phase |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_src_addr_o | output | 32 | Updated source pointer |
| wb_dst_addr_o | output | 32 | Updated destination pointer |
| wb_iter_o | output | 16 | Updated iteration count |
| minor_done_o | output | 1 | Minor loop complete pulse |
| major_done_o | output | 1 | Major loop complete pulse |

## Verification
Several rules are checked on every cycle: no request outside the busy window, steady address-phase signals under stall, natural alignment of every address, a single write-back cycle followed by idle, exactly one completion pulse per write-back, and silence on the bus after a rejection. Three behaviours need the bench's scenarios: the order of reads and writes within each group, the byte-exact contents of the destination, and the arithmetic of the written-back pointers and counts under signed offsets and major-loop reload. The bench runs these with mixed sizes, random bus stalls, and a second start sent mid-transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {SZ_B8 = 2'd0, SZ_B16 = 2'd1, SZ_B32 = 2'd2, SZ_BAD = 2'd3} acc_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_WB} seq_state_e;
endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg #(
  parameter int NBW   = 16,
  parameter int CW    = 16,
  parameter int LW    = 2,
  parameter int IW    = LW + 1
) (
  input  logic [1:0]     src_size_i,
  input  logic [1:0]     dst_size_i,
  input  logic [NBW-1:0] bytes_i,
  input  logic [CW-1:0]  iter_i,
  output logic [IW-1:0]  rd_last_o,
  output logic [IW-1:0]  wr_last_o,
  output logic [NBW-1:0] groups_o,
  output logic           bad_o
);
  logic [1:0]     grp_code;
  logic [NBW-1:0] grp_mask;

  assign grp_code  = (src_size_i > dst_size_i) ? src_size_i : dst_size_i;
  assign grp_mask  = NBW'((32'd1 << grp_code) - 32'd1);
  assign rd_last_o = IW'((32'd1 << (grp_code - src_size_i)) - 32'd1);
  assign wr_last_o = IW'((32'd1 << (grp_code - dst_size_i)) - 32'd1);
  assign groups_o  = bytes_i >> grp_code;
  assign bad_o     = (32'(src_size_i) > LW) || (32'(dst_size_i) > LW) ||
                     (bytes_i == '0) || (iter_i == '0) || ((bytes_i & grp_mask) != '0);
endmodule

// File: rtl/dma_seq_buf.sv
module dma_seq_buf #(
  parameter int DW    = 32,
  parameter int LANES = DW / 8,
  parameter int LW    = $clog2(LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [LW-1:0] cap_pos_i,
  input  logic [LW-1:0] cap_lane_i,
  input  logic [1:0]    cap_size_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          out_en_i,
  input  logic [LW-1:0] out_pos_i,
  input  logic [LW-1:0] out_lane_i,
  input  logic [1:0]    out_size_i,
  output logic [DW-1:0] wdata_o
);
  logic [DW-1:0]    store_q;
  logic [DW-1:0]    placed, picked, keep;
  logic [LANES-1:0] cap_be;

  // align read bytes to lane 0, then move them to their slot in the buffer
  assign placed = (rdata_i >> {cap_lane_i, 3'b000}) << {cap_pos_i, 3'b000};

  always_comb begin
    for (int d = 0; d < LANES; d++) begin
      cap_be[d]       = (d >= int'(cap_pos_i)) && (d < int'(cap_pos_i) + (1 << cap_size_i));
      keep[8*d +: 8]  = (d < (1 << out_size_i)) ? 8'hff : 8'h00;
    end
  end

  for (genvar d = 0; d < LANES; d++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 store_q[8*d +: 8] <= '0;
      else if (cap_i && cap_be[d]) store_q[8*d +: 8] <= placed[8*d +: 8];
    end
  end

  assign picked  = (store_q >> {out_pos_i, 3'b000}) & keep;
  assign wdata_o = out_en_i ? (picked << {out_lane_i, 3'b000}) : '0;
endmodule

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] init_i,
  input  logic          step_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] off_ext;
  assign off_ext = {{(AW-OW){off_i[OW-1]}}, off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= init_i;
    else if (step_i) addr_o <= addr_o + off_ext;
  end
endmodule

// File: rtl/dma_minor_seq.sv
module dma_minor_seq
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int OW  = 16,
  parameter int NBW = 16,
  parameter int CW  = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  src_addr_i,
  input  logic [AW-1:0]  dst_addr_i,
  input  logic [OW-1:0]  src_step_i,
  input  logic [OW-1:0]  dst_step_i,
  input  logic [1:0]     src_size_i,
  input  logic [1:0]     dst_size_i,
  input  logic [NBW-1:0] minor_bytes_i,
  input  logic [CW-1:0]  iter_cur_i,
  input  logic [CW-1:0]  iter_start_i,
  input  logic [AW-1:0]  src_adj_i,
  input  logic [AW-1:0]  dst_adj_i,
  output logic           busy_o,
  output logic           err_o,
  output logic           bus_req_o,
  output logic           bus_we_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [1:0]     bus_size_o,
  input  logic           bus_ready_i,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic [DW-1:0]  bus_rdata_i,
  output logic           wb_valid_o,
  output logic [AW-1:0]  wb_src_addr_o,
  output logic [AW-1:0]  wb_dst_addr_o,
  output logic [CW-1:0]  wb_iter_o,
  output logic           minor_done_o,
  output logic           major_done_o
);
  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);
  localparam int IW    = LW + 1;

  seq_state_e     state_q;
  logic [1:0]     ssize_q, dsize_q;
  logic [AW-1:0]  sadj_q, dadj_q;
  logic [OW-1:0]  soff_q, doff_q;
  logic [CW-1:0]  iter_q, iter0_q;
  logic [NBW-1:0] grp_q;
  logic [IW-1:0]  rd_idx_q, wr_idx_q, rd_last_q, wr_last_q;
  logic           rd_ph_q, wr_ph_q, err_q;
  logic [LW-1:0]  rd_pos_q, rd_lane_q, wr_pos_q, wr_lane_q;

  logic [IW-1:0]  cfg_rd_last, cfg_wr_last;
  logic [NBW-1:0] cfg_groups;
  logic           cfg_bad, accept, load, last_iter;
  logic [AW-1:0]  ptr_init [2];
  logic [OW-1:0]  ptr_off  [2];
  logic [AW-1:0]  ptr_addr [2];
  logic           ptr_step [2];
  logic [LW-1:0]  rd_pos, wr_pos;

  dma_seq_cfg #(.NBW(NBW), .CW(CW), .LW(LW), .IW(IW)) u_cfg (
    .src_size_i(src_size_i), .dst_size_i(dst_size_i), .bytes_i(minor_bytes_i),
    .iter_i(iter_cur_i), .rd_last_o(cfg_rd_last), .wr_last_o(cfg_wr_last),
    .groups_o(cfg_groups), .bad_o(cfg_bad)
  );

  assign accept = bus_req_o & bus_ready_i;
  assign load   = (state_q == ST_IDLE) && start_i && !cfg_bad;

  // index 0 = source pointer, 1 = destination pointer
  assign ptr_init[0] = src_addr_i;
  assign ptr_init[1] = dst_addr_i;
  assign ptr_off[0]  = soff_q;
  assign ptr_off[1]  = doff_q;
  assign ptr_step[0] = accept && !bus_we_o;
  assign ptr_step[1] = accept && bus_we_o;

  for (genvar p = 0; p < 2; p++) begin : g_ptr
    dma_seq_ptr #(.AW(AW), .OW(OW)) u_ptr (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .init_i(ptr_init[p]),
      .step_i(ptr_step[p]), .off_i(ptr_off[p]), .addr_o(ptr_addr[p])
    );
  end

  assign rd_pos = LW'(rd_idx_q << ssize_q);
  assign wr_pos = LW'(wr_idx_q << dsize_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ssize_q   <= '0;  dsize_q  <= '0;
      soff_q    <= '0;  doff_q   <= '0;
      sadj_q    <= '0;  dadj_q   <= '0;
      iter_q    <= '0;  iter0_q  <= '0;
      grp_q     <= '0;
      rd_idx_q  <= '0;  wr_idx_q <= '0;
      rd_last_q <= '0;  wr_last_q <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (cfg_bad) err_q <= 1'b1;
          else begin
            state_q   <= ST_READ;
            ssize_q   <= src_size_i;    dsize_q   <= dst_size_i;
            soff_q    <= src_step_i;    doff_q    <= dst_step_i;
            sadj_q    <= src_adj_i;     dadj_q    <= dst_adj_i;
            iter_q    <= iter_cur_i;    iter0_q   <= iter_start_i;
            grp_q     <= cfg_groups;
            rd_last_q <= cfg_rd_last;   wr_last_q <= cfg_wr_last;
            rd_idx_q  <= '0;            wr_idx_q  <= '0;
          end
        end
        ST_READ: if (accept) begin
          if (rd_idx_q == rd_last_q) begin
            rd_idx_q <= '0;
            state_q  <= ST_WRITE;
          end else rd_idx_q <= rd_idx_q + 1'b1;
        end
        ST_WRITE: if (accept) begin
          if (wr_idx_q == wr_last_q) begin
            wr_idx_q <= '0;
            grp_q    <= grp_q - 1'b1;
            state_q  <= (grp_q == NBW'(1)) ? ST_WB : ST_READ;
          end else wr_idx_q <= wr_idx_q + 1'b1;
        end
        ST_WB: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // data-phase tracking: one cycle behind address acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ph_q <= 1'b0; wr_ph_q <= 1'b0;
      rd_pos_q <= '0; rd_lane_q <= '0; wr_pos_q <= '0; wr_lane_q <= '0;
    end else begin
      rd_ph_q <= accept && !bus_we_o;
      wr_ph_q <= accept && bus_we_o;
      if (accept && !bus_we_o) begin
        rd_pos_q  <= rd_pos;
        rd_lane_q <= ptr_addr[0][LW-1:0];
      end
      if (accept && bus_we_o) begin
        wr_pos_q  <= wr_pos;
        wr_lane_q <= ptr_addr[1][LW-1:0];
      end
    end
  end

  dma_seq_buf #(.DW(DW), .LANES(LANES), .LW(LW)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap_i(rd_ph_q), .cap_pos_i(rd_pos_q), .cap_lane_i(rd_lane_q), .cap_size_i(ssize_q),
    .rdata_i(bus_rdata_i),
    .out_en_i(wr_ph_q), .out_pos_i(wr_pos_q), .out_lane_i(wr_lane_q), .out_size_i(dsize_q),
    .wdata_o(bus_wdata_o)
  );

  assign busy_o     = (state_q != ST_IDLE);
  assign err_o      = err_q;
  assign bus_req_o  = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_we_o   = (state_q == ST_WRITE);
  assign bus_addr_o = bus_we_o ? ptr_addr[1] : ptr_addr[0];
  assign bus_size_o = bus_we_o ? dsize_q : ssize_q;

  assign last_iter     = (iter_q == CW'(1));
  assign wb_valid_o    = (state_q == ST_WB);
  assign wb_src_addr_o = ptr_addr[0] + (last_iter ? sadj_q : '0);
  assign wb_dst_addr_o = ptr_addr[1] + (last_iter ? dadj_q : '0);
  assign wb_iter_o     = last_iter ? iter0_q : iter_q - 1'b1;
  assign minor_done_o  = wb_valid_o && !last_iter;
  assign major_done_o  = wb_valid_o && last_iter;
endmodule

// File: rtl/dma_minor_seq_chk.sv
module dma_minor_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          err_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    bus_size_o,
  input logic          bus_ready_i,
  input logic          wb_valid_o,
  input logic          minor_done_o,
  input logic          major_done_o
);
  assert_req_in_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  assert_busy_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !wb_valid_o |=> busy_o);

  assert_idle_after_wb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !busy_o && !wb_valid_o);

  assert_reject_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !bus_req_o);

  assert_reject_after_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !bus_req_o && !err_o);

  assert_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_size_o != 2'd3) &&
                  ((bus_size_o == 2'd0) || (bus_size_o == 2'd1 && !bus_addr_o[0]) ||
                   (bus_size_o == 2'd2 && bus_addr_o[1:0] == 2'b00)));

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o) &&
                                  $stable(bus_we_o) && $stable(bus_size_o));

  assert_one_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({minor_done_o, major_done_o}) == (wb_valid_o ? 1 : 0));

  assert_major_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    major_done_o |=> !major_done_o && !minor_done_o);
endmodule

bind dma_minor_seq dma_minor_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .err_o(err_o),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_size_o(bus_size_o), .bus_ready_i(bus_ready_i), .wb_valid_o(wb_valid_o),
  .minor_done_o(minor_done_o), .major_done_o(major_done_o)
);

// File: tb/dma_minor_seq_test.sv
module dma_minor_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] src_addr_i = '0, dst_addr_i = '0, src_adj_i = '0, dst_adj_i = '0;
  logic [15:0] src_step_i = '0, dst_step_i = '0, minor_bytes_i = '0, iter_cur_i = '0, iter_start_i = '0;
  logic [1:0]  src_size_i = '0, dst_size_i = '0;
  logic        bus_ready_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        busy_o, err_o, bus_req_o, bus_we_o, wb_valid_o, minor_done_o, major_done_o;
  logic [31:0] bus_addr_o, bus_wdata_o, wb_src_addr_o, wb_dst_addr_o;
  logic [1:0]  bus_size_o;
  logic [15:0] wb_iter_o;

  always #2 clk = ~clk;

  dma_minor_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
    .src_step_i(src_step_i), .dst_step_i(dst_step_i),
    .src_size_i(src_size_i), .dst_size_i(dst_size_i),
    .minor_bytes_i(minor_bytes_i), .iter_cur_i(iter_cur_i), .iter_start_i(iter_start_i),
    .src_adj_i(src_adj_i), .dst_adj_i(dst_adj_i),
    .busy_o(busy_o), .err_o(err_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_size_o(bus_size_o),
    .bus_ready_i(bus_ready_i), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .wb_valid_o(wb_valid_o), .wb_src_addr_o(wb_src_addr_o), .wb_dst_addr_o(wb_dst_addr_o),
    .wb_iter_o(wb_iter_o), .minor_done_o(minor_done_o), .major_done_o(major_done_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  bit rdy_rand = 1'b0;
  logic [7:0] mem [1024];
  logic [7:0] exp_mem [1024];
  logic [7:0] stream [256];
  bit   op_we [512];
  logic [1:0] op_sz [512];
  int   op_n = 0;
  bit   ph_v = 1'b0, ph_we = 1'b0;
  logic [31:0] ph_a = '0;
  logic [1:0]  ph_sz = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus slave: everything happens on the falling edge
  always @(negedge clk) begin
    bus_rdata_i = $urandom;
    if (ph_v) begin
      if (ph_we) begin
        for (int b = 0; b < (1 << ph_sz); b++)
          mem[(int'(ph_a) + b) & 1023] = bus_wdata_o[8*((int'(ph_a[1:0]) + b) & 3) +: 8];
      end else begin
        for (int k = 0; k < 4; k++)
          bus_rdata_i[8*k +: 8] = mem[((int'(ph_a) & ~3) + k) & 1023];
      end
    end
    ph_v = 1'b0;
    bus_ready_i = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
    if (rst_n && bus_req_o && bus_ready_i) begin
      ph_v = 1'b1; ph_we = bus_we_o; ph_a = bus_addr_o; ph_sz = bus_size_o;
      if (op_n < 512) begin
        op_we[op_n] = bus_we_o;
        op_sz[op_n] = bus_size_o;
      end
      op_n++;
    end
  end

  function automatic logic [31:0] exp_ptr(input logic [31:0] base, input int n, input int off,
                                          input bit major, input logic [31:0] adj);
    return base + 32'(n * off) + (major ? adj : 32'd0);
  endfunction

  task automatic run_case(input int ss, input int ds, input int soff, input int doff, input int nb,
                          input int cit, input int bit0, input logic [31:0] sadj,
                          input logic [31:0] dadj, input int sa, input int da, input bit poke);
    int nrd, nwr, sb, db, rpg, wpg, t, seq_bad, mem_bad, first;
    bit got;
    sb = 1 << ss; db = 1 << ds;
    nrd = nb / sb; nwr = nb / db;
    rpg = ((ss > ds) ? sb : db) / sb;
    wpg = ((ss > ds) ? sb : db) / db;
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < nrd; i++)
      for (int b = 0; b < sb; b++) stream[i*sb + b] = exp_mem[(sa + i*soff + b) & 1023];
    for (int j = 0; j < nwr; j++)
      for (int b = 0; b < db; b++) exp_mem[(da + j*doff + b) & 1023] = stream[j*db + b];

    @(negedge clk);
    src_addr_i = 32'(sa); dst_addr_i = 32'(da);
    src_step_i = 16'(soff); dst_step_i = 16'(doff);
    src_size_i = 2'(ss); dst_size_i = 2'(ds);
    minor_bytes_i = 16'(nb); iter_cur_i = 16'(cit); iter_start_i = 16'(bit0);
    src_adj_i = sadj; dst_adj_i = dadj;
    op_n = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R1", "busy after start", 64'(busy_o), 64'd1);
    if (poke) begin
      repeat (2) @(negedge clk);
      src_addr_i = 32'h0; dst_addr_i = 32'h0; minor_bytes_i = 16'd4;
      src_size_i = 2'd0; dst_size_i = 2'd0; iter_cur_i = 16'd9;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    got = 1'b0;
    for (t = 0; t < 4000; t++) begin
      if (wb_valid_o === 1'b1) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check(got, "R8", "write-back strobe seen", 64'(got), 64'd1);
    check(wb_src_addr_o === exp_ptr(32'(sa), nrd, soff, cit == 1, sadj), "R7",
          "written-back source pointer", 64'(wb_src_addr_o), 64'(exp_ptr(32'(sa), nrd, soff, cit == 1, sadj)));
    check(wb_dst_addr_o === exp_ptr(32'(da), nwr, doff, cit == 1, dadj), "R7",
          "written-back destination pointer", 64'(wb_dst_addr_o), 64'(exp_ptr(32'(da), nwr, doff, cit == 1, dadj)));
    if (cit == 1) begin
      check(wb_iter_o === 16'(bit0), "R9", "reloaded count", 64'(wb_iter_o), 64'(bit0));
      check(major_done_o === 1'b1 && minor_done_o === 1'b0, "R9", "major pulse",
            64'({major_done_o, minor_done_o}), 64'b10);
    end else begin
      check(wb_iter_o === 16'(cit - 1), "R8", "decremented count", 64'(wb_iter_o), 64'(cit - 1));
      check(minor_done_o === 1'b1 && major_done_o === 1'b0, "R8", "minor pulse",
            64'({major_done_o, minor_done_o}), 64'b01);
    end
    @(negedge clk);
    check(busy_o === 1'b0 && wb_valid_o === 1'b0, "R1", "idle after write-back",
          64'({busy_o, wb_valid_o}), 64'd0);
    repeat (2) @(negedge clk);
    check(op_n == nrd + nwr, ss == ds ? "R3" : "R4", "access count", 64'(op_n), 64'(nrd + nwr));
    seq_bad = 0;
    for (int k = 0; k < op_n && k < 512; k++) begin
      bit ew;
      ew = (k % (rpg + wpg)) >= rpg;
      if (op_we[k] != ew) seq_bad++;
      if (int'(op_sz[k]) != (ew ? ds : ss)) seq_bad++;
    end
    check(seq_bad == 0, ss == ds ? "R3" : "R4", "read/write order and R5 sizes", 64'(seq_bad), 64'd0);
    mem_bad = 0; first = -1;
    for (int i = 512; i < 1024; i++)
      if (mem[i] !== exp_mem[i]) begin
        mem_bad++;
        if (first < 0) first = i;
      end
    check(mem_bad == 0, "R10", "destination bytes via R5 lanes", 64'(first < 0 ? 0 : mem[first]),
          64'(first < 0 ? 0 : exp_mem[first]));
  endtask

  task automatic reject_case(input int ss, input int ds, input int nb, input int cit, input string why);
    @(negedge clk);
    src_size_i = 2'(ss); dst_size_i = 2'(ds); minor_bytes_i = 16'(nb); iter_cur_i = 16'(cit);
    src_addr_i = 32'h100; dst_addr_i = 32'h300;
    op_n = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o === 1'b1 && busy_o === 1'b0, "R2", why, 64'({err_o, busy_o}), 64'b10);
    repeat (5) @(negedge clk);
    check(op_n == 0 && err_o === 1'b0 && busy_o === 1'b0, "R2", "no traffic after reject",
          64'(op_n), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0d4a));
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && bus_req_o === 1'b0 && wb_valid_o === 1'b0 && err_o === 1'b0,
          "R1", "reset state", 64'({busy_o, bus_req_o, wb_valid_o, err_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: pack 16-bit reads into 32-bit writes, major end
    run_case(1, 2, 2, 4, 8, 1, 5, 32'hffff_fff0, 32'h0000_0020, 'h100, 'h300, 1'b0);
    // split 32-bit reads into byte writes, minor end
    run_case(2, 0, 4, 1, 8, 3, 3, 32'h0, 32'h0, 'h104, 'h301, 1'b0);
    // equal byte sizes with negative offsets
    run_case(0, 0, -1, -1, 4, 2, 7, 32'h0, 32'h0, 'h120, 'h320, 1'b0);
    // 8-bit into 32-bit with stalls and a start sent while busy
    rdy_rand = 1'b1;
    run_case(0, 2, 1, 4, 12, 1, 2, 32'h40, 32'hffff_ffc0, 'h100, 'h300, 1'b1);
    rdy_rand = 1'b0;
    // rejected descriptors
    reject_case(1, 2, 6, 1, "byte count not multiple of larger size");
    reject_case(0, 0, 0, 1, "zero byte count");
    reject_case(3, 0, 4, 1, "size code 3");
    reject_case(0, 1, 4, 0, "zero iteration count");

    for (int n = 0; n < 40; n++) begin
      int ss, ds, g, nb, soff, doff;
      rdy_rand = n[0];
      ss = $urandom % 3; ds = $urandom % 3;
      g = 1 << ((ss > ds) ? ss : ds);
      nb = g * (1 + $urandom % 4);
      soff = (1 << ss) * (int'($urandom % 4) - 1);
      doff = (1 << ds) * (int'($urandom % 4) - 1);
      run_case(ss, ds, soff, doff, nb, 1 + $urandom % 3, 1 + $urandom % 5,
               $urandom, $urandom, 'h100 + 4 * ($urandom % 8), 'h300 + 4 * ($urandom % 8), n % 7 == 3);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule